// File: doc/BRIEF.md
# Disk Controller Reset Manager

This block gathers every way a floppy-style disk controller can be reset and turns them into one controller reset. Four sources feed it. Two are hard: a power-on indication and an external reset pin. Two are soft, set by host writes: a run/hold bit in the drive output register and a self-clearing reset bit in the data-rate register. The hard sources are combined and asserted asynchronously. Their release is synchronized and then stretched by a hold counter. Each hard reset also forces the output-register bit into its hold state, so the controller stays in reset until the host writes that bit back to run.

Beyond the reset itself, the block decides what each reset keeps and what it discards. Any reset aborts the operation in progress and leaves power-down. On the way out of reset it pulses a clear for the configure parameters and re-arms drive polling. The parameters loaded by the specify command survive every reset except power-on. A reset that lands during a disk write simply aborts it, and the data and CRC on the medium may be left corrupt.

Top module: `fdc_reset_mgr`

## Requirements
- R1: Driving `rst_pin_n` or `por_n` low asserts `core_rst` and `op_abort` without waiting for a clock. After both are high again, the hard reset lasts SYNC_STAGES+HOLD_CYCLES rising edges (2+16 by default). A run write held on the bus during that time takes effect no earlier than the 19th edge after release.
- R2: Once a hard reset has completed, `core_rst` stays high until the host writes the run bit to 1. The run bit is bit 2 of address 2 (1 = run, 0 = hold). `core_rst` falls after the edge that samples that write.
- R3: A host write of 0 to the run bit (bit 2, address 2) puts the controller back into reset. It stays there until the bit is written to 1.
- R4: A host write to address 4 with bit 7 set raises `core_rst` for exactly one cycle. A write to address 4 with bit 7 clear has no effect.
- R5: `cfg_clr` is high for exactly one cycle: the first cycle after `core_rst` falls. It is low at all other times.
- R6: `poll_en` is 1 during and after every reset. A configure command (`cfg_wr`) outside reset sets `poll_en` to the inverse of `cfg_poll_dis`.
- R7: `pd_enter` outside reset sets `pwr_down`. Any reset source clears it: a hard source at once, a soft source at the next edge.
- R8: `spec_q` loads `spec_data` on `spec_wr` outside reset, and `spec_wr` during reset is ignored. `spec_q` keeps its value through pin, run-bit and data-rate resets. Only `por_n` low returns it to SPEC_INIT (0).
- R9: Host writes to any address other than 2 and 4 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host register address |
| wr_data | input | DATA_W | Host write data |
| pd_enter | input | 1 | Request from the engine to enter power-down |
| cfg_wr | input | 1 | Configure command executed |
| cfg_poll_dis | input | 1 | Polling-disable field of the configure command |
| spec_wr | input | 1 | Specify command executed |
| spec_data | input | SPEC_W | Specify parameters |
| core_rst | output | 1 | Controller reset, active high |
| op_abort | output | 1 | Abort the operation in progress |
| cfg_clr | output | 1 | One-cycle clear of the configure parameters |
| pwr_down | output | 1 | Controller is in power-down |
| poll_en | output | 1 | Drive polling enabled |
| spec_q | output | SPEC_W | Retained specify parameters |

## Verification
The bound assertions check several rules on every cycle:
- the pin forces the reset;
- a data-rate reset write is followed by reset;
- the exit clear is a single pulse that only follows reset;
- polling is re-armed and power-down is dropped after any reset cycle;
- the specify parameters stay stable unless they are loaded outside reset.

Three behaviours can only be shown by the bench's scenarios:
- the exact length of the synchronizer and hold stretch;
- the controller staying in reset after a hard reset until the run bit is written;
- power-on, and not the pin, restoring the specify parameters.

// File: rtl/fdc_rstm_pkg.sv
package fdc_rstm_pkg;

   // Levels of the individual reset contributors, combined in the top.
   typedef struct packed {
      logic hard;   // pin or power-on, still synchronizing or holding
      logic hold;   // run bit in the output register is in hold
      logic pulse;  // one-cycle data-rate register reset
   } rst_src_t;

   function automatic logic any_src(input rst_src_t s);
      return s.hard | s.hold | s.pulse;
   endfunction

endpackage

// File: rtl/fdc_rstm_sync.sv
module fdc_rstm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rel_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rel_n = chain_q[STAGES-1];
endmodule

// File: rtl/fdc_rstm_hold.sv
module fdc_rstm_hold #(
   parameter int unsigned HOLD = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rel_n,
   output logic hold_act
);
   generate
      if (HOLD == 0) begin : g_bypass
         assign hold_act = ~rel_n;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HOLD + 1);
         localparam logic [CW-1:0] LAST = CW'(HOLD);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)          cnt_q <= '0;
            else if (!rel_n)      cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end

         assign hold_act = (cnt_q != LAST);
      end
   endgenerate
endmodule

// File: rtl/fdc_rstm_hostregs.sv
module fdc_rstm_hostregs #(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RUN_ADDR = 2,
   parameter int unsigned RATE_ADDR = 4,
   parameter int unsigned RUN_BIT  = 2,
   parameter int unsigned RATE_BIT = 7
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              hard_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              run_q,
   output logic              pulse_q
);
   logic run_hit, rate_hit;

   assign run_hit  = wr_en && (wr_addr == ADDR_W'(RUN_ADDR));
   assign rate_hit = wr_en && (wr_addr == ADDR_W'(RATE_ADDR));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         run_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= rate_hit && wr_data[RATE_BIT];
         if (hard_rst)     run_q <= 1'b0;
         else if (run_hit) run_q <= wr_data[RUN_BIT];
      end
   end
endmodule

// File: rtl/fdc_reset_mgr.sv
module fdc_reset_mgr
   import fdc_rstm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned RUN_ADDR    = 2,
   parameter int unsigned RATE_ADDR   = 4,
   parameter int unsigned RUN_BIT     = 2,
   parameter int unsigned RATE_BIT    = 7,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 16,
   parameter int unsigned SPEC_W      = 16,
   parameter logic [SPEC_W-1:0] SPEC_INIT = '0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pd_enter,
   input  logic              cfg_wr,
   input  logic              cfg_poll_dis,
   input  logic              spec_wr,
   input  logic [SPEC_W-1:0] spec_data,
   output logic              core_rst,
   output logic              op_abort,
   output logic              cfg_clr,
   output logic              pwr_down,
   output logic              poll_en,
   output logic [SPEC_W-1:0] spec_q
);
   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RUN_ADDR == RATE_ADDR) begin : g_chk_addr
      $error("RUN_ADDR and RATE_ADDR must differ");
   end
   if (RUN_ADDR >= (1 << ADDR_W) || RATE_ADDR >= (1 << ADDR_W)) begin : g_chk_range
      $error("register address outside ADDR_W");
   end
   if (RUN_BIT >= DATA_W || RATE_BIT >= DATA_W) begin : g_chk_bit
      $error("control bit outside DATA_W");
   end

   logic     hard_arst_n;
   logic     hard_rel_n, por_rel_n, hold_act;
   logic     run_q, pulse_q;
   logic     core_d_q;
   rst_src_t src;

   assign hard_arst_n = por_n & rst_pin_n;

   fdc_rstm_sync #(.STAGES(SYNC_STAGES)) u_hard_sync (
      .clk    (clk),
      .arst_n (hard_arst_n),
      .rel_n  (hard_rel_n)
   );

   fdc_rstm_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
      .clk    (clk),
      .arst_n (por_n),
      .rel_n  (por_rel_n)
   );

   fdc_rstm_hold #(.HOLD(HOLD_CYCLES)) u_hold (
      .clk      (clk),
      .arst_n   (hard_arst_n),
      .rel_n    (hard_rel_n),
      .hold_act (hold_act)
   );

   assign src.hard  = ~hard_rel_n | hold_act;

   fdc_rstm_hostregs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .RUN_ADDR  (RUN_ADDR),
      .RATE_ADDR (RATE_ADDR),
      .RUN_BIT   (RUN_BIT),
      .RATE_BIT  (RATE_BIT)
   ) u_regs (
      .clk      (clk),
      .arst_n   (hard_arst_n),
      .hard_rst (src.hard),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .run_q    (run_q),
      .pulse_q  (pulse_q)
   );

   assign src.hold  = ~run_q;
   assign src.pulse = pulse_q;

   assign core_rst = any_src(src);
   assign op_abort = core_rst;

   // Reset exit detection: configure clear pulses on the first free cycle.
   always_ff @(posedge clk or negedge hard_arst_n) begin
      if (!hard_arst_n) core_d_q <= 1'b1;
      else              core_d_q <= core_rst;
   end
   assign cfg_clr = core_d_q & ~core_rst;

   // Power-down state and polling enable.
   always_ff @(posedge clk or negedge hard_arst_n) begin
      if (!hard_arst_n) begin
         pwr_down <= 1'b0;
         poll_en  <= 1'b1;
      end else if (core_rst) begin
         pwr_down <= 1'b0;
         poll_en  <= 1'b1;
      end else begin
         if (pd_enter) pwr_down <= 1'b1;
         if (cfg_wr)   poll_en  <= ~cfg_poll_dis;
      end
   end

   // Specify parameters: only power-on initializes them.
   always_ff @(posedge clk or negedge por_rel_n) begin
      if (!por_rel_n)                 spec_q <= SPEC_INIT;
      else if (spec_wr && !core_rst)  spec_q <= spec_data;
   end
endmodule

// File: rtl/fdc_reset_mgr_chk.sv
module fdc_reset_mgr_chk #(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RATE_ADDR = 4,
   parameter int unsigned RATE_BIT  = 7,
   parameter int unsigned SPEC_W    = 16
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_pin_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              spec_wr,
   input logic              core_rst,
   input logic              cfg_clr,
   input logic              pwr_down,
   input logic              poll_en,
   input logic [SPEC_W-1:0] spec_q
);
   logic arst_n;
   assign arst_n = por_n & rst_pin_n;

   AST_PIN_FORCES_RST: assert property (@(posedge clk) disable iff (!por_n)
      !rst_pin_n |-> core_rst); // R1

   AST_RATE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
      (wr_en && wr_addr == ADDR_W'(RATE_ADDR) && wr_data[RATE_BIT]) |=> core_rst); // R4

   AST_CLR_AFTER_RST: assert property (@(posedge clk) disable iff (!arst_n)
      cfg_clr |-> (!core_rst && $past(core_rst))); // R5

   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
      cfg_clr |=> !cfg_clr); // R5

   AST_POLL_REARM: assert property (@(posedge clk) disable iff (!arst_n)
      core_rst |=> poll_en); // R6

   AST_PD_DROP: assert property (@(posedge clk) disable iff (!arst_n)
      core_rst |=> !pwr_down); // R7

   AST_SPEC_KEEP: assert property (@(posedge clk) disable iff (!por_n)
      !(spec_wr && !core_rst) |=> $stable(spec_q)); // R8
endmodule

bind fdc_reset_mgr fdc_reset_mgr_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .RATE_ADDR (RATE_ADDR),
   .RATE_BIT  (RATE_BIT),
   .SPEC_W    (SPEC_W)
) chk_i (
   .clk       (clk),
   .por_n     (por_n),
   .rst_pin_n (rst_pin_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .spec_wr   (spec_wr),
   .core_rst  (core_rst),
   .cfg_clr   (cfg_clr),
   .pwr_down  (pwr_down),
   .poll_en   (poll_en),
   .spec_q    (spec_q)
);

// File: tb/fdc_reset_mgr_tb_top.sv
`timescale 1ns/1ps
module fdc_reset_mgr_tb_top;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int SW = 16;
   localparam int SYNC = 2;
   localparam int HOLD = 16;
   localparam logic [AW-1:0] A_RUN  = 3'd2;
   localparam logic [AW-1:0] A_RATE = 3'd4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic por_n = 1'b0, rst_pin_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic pd_enter = 1'b0, cfg_wr = 1'b0, cfg_poll_dis = 1'b0, spec_wr = 1'b0;
   logic [SW-1:0] spec_data = '0;
   logic core_rst, op_abort, cfg_clr, pwr_down, poll_en;
   logic [SW-1:0] spec_q;

   fdc_reset_mgr dut_i (
      .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pd_enter(pd_enter), .cfg_wr(cfg_wr), .cfg_poll_dis(cfg_poll_dis),
      .spec_wr(spec_wr), .spec_data(spec_data),
      .core_rst(core_rst), .op_abort(op_abort), .cfg_clr(cfg_clr),
      .pwr_down(pwr_down), .poll_en(poll_en), .spec_q(spec_q)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic arst_tb;
   assign arst_tb = por_n & rst_pin_n;
   int m_sync = 0, m_hold = 0;
   bit m_run = 0, m_pulse = 0, m_cored = 1, m_pd = 0, m_poll = 1;
   logic [SW-1:0] m_spec = '0;

   function automatic bit m_hard();
      return (m_sync != SYNC) || (m_hold != HOLD);
   endfunction
   function automatic bit m_core();
      return m_hard() || !m_run || m_pulse;
   endfunction

   always @(posedge clk or negedge arst_tb or negedge por_n) begin
      if (!por_n) m_spec = '0;
      if (!arst_tb) begin
         m_sync = 0; m_hold = 0; m_run = 0; m_pulse = 0;
         m_cored = 1; m_pd = 0; m_poll = 1;
      end else begin
         bit hard_o, core_o;
         int sync_o;
         hard_o = m_hard();
         core_o = m_core();
         sync_o = m_sync;
         m_sync = (m_sync < SYNC) ? m_sync + 1 : SYNC;
         if (sync_o != SYNC) m_hold = 0;
         else if (m_hold != HOLD) m_hold = m_hold + 1;
         m_pulse = wr_en && (wr_addr == A_RATE) && wr_data[7];
         if (hard_o) m_run = 0;
         else if (wr_en && wr_addr == A_RUN) m_run = wr_data[2];
         m_cored = core_o;
         if (core_o) begin m_pd = 0; m_poll = 1; end
         else begin
            if (pd_enter) m_pd = 1;
            if (cfg_wr) m_poll = !cfg_poll_dis;
         end
         if (spec_wr && !core_o) m_spec = spec_data;
      end
   end

   // Compare on every cycle, away from the active edge.
   always @(negedge clk) begin
      if (!done) begin
         chk("R1 core_rst model", core_rst, m_core());
         chk("R1 op_abort model", op_abort, m_core());
         chk("R5 cfg_clr model", cfg_clr, m_cored && !m_core());
         chk("R7 pwr_down model", pwr_down, m_pd);
         chk("R6 poll_en model", poll_en, m_poll);
         chk("R8 spec_q model", spec_q, m_spec);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask
   task automatic look();
      @(negedge clk); #0.2;
   endtask
   task automatic hwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 0;
   endtask
   task automatic release_and_run();
      int n;
      wr_en = 1; wr_addr = A_RUN; wr_data = 8'h04;
      n = 0;
      do begin tick(); n++; look(); end while (core_rst && n < 100);
      wr_en = 0;
      chk("R1 hard reset stretch edges", n, SYNC + HOLD + 1);
      chk("R5 clear on exit", cfg_clr, 1);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      look();
      chk("R1 reset state core_rst", core_rst, 1);
      chk("R1 reset state op_abort", op_abort, 1);
      chk("R6 reset state poll_en", poll_en, 1);
      chk("R7 reset state pwr_down", pwr_down, 0);
      chk("R8 reset state spec_q", spec_q, 16'h0000);
      tick();
      por_n = 1; rst_pin_n = 1;
      release_and_run();
      tick(); look();
      chk("R5 clear is single", cfg_clr, 0);

      spec_wr = 1; spec_data = 16'hBEEF; tick(); spec_wr = 0; look();
      chk("R8 spec load", spec_q, 16'hBEEF);
      cfg_wr = 1; cfg_poll_dis = 1; tick(); cfg_wr = 0; look();
      chk("R6 configure disables polling", poll_en, 0);
      pd_enter = 1; tick(); pd_enter = 0; look();
      chk("R7 enter power-down", pwr_down, 1);

      hwr(3'd3, 8'h00); hwr(3'd5, 8'hFF); hwr(3'd0, 8'h00); hwr(3'd6, 8'h84); look();
      chk("R9 other addresses core_rst", core_rst, 0);
      chk("R9 other addresses pwr_down", pwr_down, 1);
      chk("R9 other addresses poll_en", poll_en, 0);

      hwr(A_RATE, 8'h7F); look();
      chk("R4 rate write bit7 clear", core_rst, 0);
      hwr(A_RATE, 8'h80); look();
      chk("R4 rate pulse high", core_rst, 1);
      chk("R1 abort with rate reset", op_abort, 1);
      tick(); look();
      chk("R4 rate pulse one cycle", core_rst, 0);
      chk("R5 clear after rate reset", cfg_clr, 1);
      chk("R7 rate reset leaves power-down", pwr_down, 0);
      chk("R6 polling re-armed", poll_en, 1);
      chk("R8 spec kept over rate reset", spec_q, 16'hBEEF);

      pd_enter = 1; tick(); pd_enter = 0;
      hwr(A_RUN, 8'h00); look();
      chk("R3 run bit hold", core_rst, 1);
      repeat (5) tick(); look();
      chk("R3 hold persists", core_rst, 1);
      chk("R7 run-bit reset leaves power-down", pwr_down, 0);
      hwr(A_RUN, 8'h04); look();
      chk("R3 run bit release", core_rst, 0);
      chk("R5 clear after run-bit reset", cfg_clr, 1);

      cfg_wr = 1; cfg_poll_dis = 1; pd_enter = 1; tick();
      cfg_wr = 0; pd_enter = 0;
      rst_pin_n = 0; look();
      chk("R1 pin asserts at once", core_rst, 1);
      chk("R7 pin leaves power-down", pwr_down, 0);
      chk("R6 pin re-arms polling", poll_en, 1);
      tick(); tick();
      rst_pin_n = 1;
      repeat (40) tick(); look();
      chk("R2 stays in reset without run write", core_rst, 1);
      chk("R8 spec kept over pin reset", spec_q, 16'hBEEF);
      spec_wr = 1; spec_data = 16'h1234; tick(); spec_wr = 0; look();
      chk("R8 spec write in reset ignored", spec_q, 16'hBEEF);
      hwr(A_RUN, 8'h04); look();
      chk("R2 run write ends reset", core_rst, 0);

      por_n = 0; tick(); tick(); por_n = 1; look();
      chk("R8 power-on restores spec", spec_q, 16'h0000);
      release_and_run();
      repeat (3) tick();
      finish_run();
   end
endmodule